// File: doc/BRIEF.md
# Shared-Bus Memory Interface Unit

This block is the memory path of a very small computer. It holds an 8-bit address register, a 4-bit buffer register and a 256-word by 4-bit RAM. All three meet on a single 4-bit data bus. An 8-bit input word has two roles. As a whole it is an address. Its low nibble is write data. Its two top bits are a command: a select bit and a direction bit.

Two active-high command strobes start the actions. The address strobe copies the whole input word into the address register. The transfer strobe acts on the command bits:
- `00` takes the low nibble of the input word into the buffer.
- `10` stores the buffer into the addressed RAM word.
- `11` takes the addressed RAM word into the buffer.
- `01` does nothing.

Each strobe passes through a two-flop synchronizer and an edge detector. One press therefore gives exactly one action, however long the strobe is held. The bus is built as a multiplexer with one-hot driver enables, picked by the command bits. The 8-bit display output shows the live bus value in its upper nibble and the buffer in its lower nibble.

Top module: `memif_top`

## Requirements
- R1: A synchronous reset clears the address register and the buffer to zero, so `disp_out[3:0]` reads 0 after reset.
- R2: A press of `strobe_a` loads all 8 bits of `sw_in` into the address register.
- R3: A press of `strobe_b` with `sw_in[7:6]` = 00 loads `sw_in[3:0]` into the buffer; `sw_in[5:4]` have no effect on the loaded value.
- R4: A press of `strobe_b` with `sw_in[7:6]` = 10 writes the buffer into the RAM word addressed by the address register, and leaves the buffer unchanged.
- R5: A press of `strobe_b` with `sw_in[7:6]` = 11 loads the RAM word addressed by the address register into the buffer.
- R6: A press of `strobe_b` with `sw_in[7:6]` = 01 changes neither register nor any RAM word.
- R7: A strobe acts once per rising edge, at the third clock edge that samples it high. Holding it high for many cycles, or changing `sw_in` while it is held, gives no further action.
- R8: The bus is driven by `sw_in[3:0]` when `sw_in[7]` = 0, by the buffer when `sw_in[7:6]` = 10, and by the addressed RAM word when `sw_in[7:6]` = 11.
- R9: `disp_out[7:4]` always shows the bus value and `disp_out[3:0]` always shows the buffer, including when the buffer is not driving the bus.
- R10: Exactly one bus driver enable is active in every cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sw_in | input | 8 | Address / data / command word |
| strobe_a | input | 1 | Address-load strobe, asynchronous, active high |
| strobe_b | input | 1 | Transfer strobe, asynchronous, active high |
| disp_out | output | 8 | {bus value, buffer contents} |

## Verification
The assertions assume that `sw_in` is stable at the clock edge where a synchronized strobe pulse acts. The stimulus therefore sets the command word on a falling edge, no later than the edge where it raises a strobe. It leaves the word unchanged until the action has taken effect. The one exception is a deliberate change while a strobe is held, and that change lands after the action.

The assertions also take RAM words as undefined until written. The stimulus writes every address before it reads it. The reference model compares the bus nibble only when the source it expects is known.

// File: rtl/memif_pkg.sv
package memif_pkg;

  typedef enum logic [1:0] {
    CMD_TAKE_EXT = 2'b00,
    CMD_IDLE     = 2'b01,
    CMD_STORE    = 2'b10,
    CMD_FETCH    = 2'b11
  } cmd_e;

  localparam int NUM_DRV = 3;
  localparam int DRV_EXT = 0;
  localparam int DRV_BUF = 1;
  localparam int DRV_RAM = 2;

  function automatic cmd_e decode_cmd(input logic sel, input logic dir);
    return cmd_e'({sel, dir});
  endfunction

  function automatic logic [NUM_DRV-1:0] driver_for(input cmd_e c);
    logic [NUM_DRV-1:0] en;
    en = '0;
    case (c)
      CMD_STORE: en[DRV_BUF] = 1'b1;
      CMD_FETCH: en[DRV_RAM] = 1'b1;
      default:   en[DRV_EXT] = 1'b1;
    endcase
    return en;
  endfunction

  function automatic logic takes_bus(input cmd_e c);
    return (c == CMD_TAKE_EXT) || (c == CMD_FETCH);
  endfunction

endpackage

// File: rtl/strobe_edge.sv
module strobe_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic strobe_in,
  output logic pulse
);
  localparam int DEPTH = SYNC_STAGES + 1;

  logic [DEPTH-1:0] sr;

  always_ff @(posedge clk) begin
    if (rst) sr <= '0;
    else     sr <= {sr[DEPTH-2:0], strobe_in};
  end

  assign pulse = sr[SYNC_STAGES-1] & ~sr[SYNC_STAGES];
endmodule

// File: rtl/cmd_decode.sv
module cmd_decode
  import memif_pkg::*;
(
  input  logic               sel,
  input  logic               dir,
  input  logic               pulse_a,
  input  logic               pulse_b,
  output cmd_e               cmd,
  output logic               addr_ld,
  output logic               buf_ld,
  output logic               mem_wr,
  output logic [NUM_DRV-1:0] drv_en
);
  always_comb begin
    cmd     = decode_cmd(sel, dir);
    drv_en  = driver_for(cmd);
    addr_ld = pulse_a;
    buf_ld  = pulse_b & takes_bus(cmd);
    mem_wr  = pulse_b & (cmd == CMD_STORE);
  end
endmodule

// File: rtl/bus_mux.sv
module bus_mux #(
  parameter int N  = 3,
  parameter int DW = 4
) (
  input  logic [N-1:0][DW-1:0] src,
  input  logic [N-1:0]         en,
  output logic [DW-1:0]        bus
);
  logic [N-1:0][DW-1:0] gated;

  for (genvar i = 0; i < N; i++) begin : g_gate
    assign gated[i] = src[i] & {DW{en[i]}};
  end

  always_comb begin
    bus = '0;
    for (int i = 0; i < N; i++) bus = bus | gated[i];
  end
endmodule

// File: rtl/word_ram.sv
module word_ram #(
  parameter int AW = 8,
  parameter int DW = 4
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int WORDS = 1 << AW;

  logic [DW-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

  assign rdata = mem[addr];
endmodule

// File: rtl/memif_top.sv
module memif_top
  import memif_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [ADDR_W-1:0]        sw_in,
  input  logic                     strobe_a,
  input  logic                     strobe_b,
  output logic [2*DATA_W-1:0]      disp_out
);
  localparam int SEL_BIT = ADDR_W - 1;
  localparam int DIR_BIT = ADDR_W - 2;

  logic                      pulse_a, pulse_b;
  logic                      addr_ld, buf_ld, mem_wr;
  cmd_e                      cmd;
  logic [NUM_DRV-1:0]        drv_en;
  logic [ADDR_W-1:0]         mar;
  logic [DATA_W-1:0]         mbr;
  logic [DATA_W-1:0]         ram_q;
  logic [DATA_W-1:0]         bus;
  logic [NUM_DRV-1:0][DATA_W-1:0] src;

  strobe_edge #(.SYNC_STAGES(SYNC_STAGES)) u_sa (
    .clk(clk), .rst(rst), .strobe_in(strobe_a), .pulse(pulse_a));
  strobe_edge #(.SYNC_STAGES(SYNC_STAGES)) u_sb (
    .clk(clk), .rst(rst), .strobe_in(strobe_b), .pulse(pulse_b));

  cmd_decode u_dec (
    .sel(sw_in[SEL_BIT]), .dir(sw_in[DIR_BIT]),
    .pulse_a(pulse_a), .pulse_b(pulse_b),
    .cmd(cmd), .addr_ld(addr_ld), .buf_ld(buf_ld),
    .mem_wr(mem_wr), .drv_en(drv_en));

  word_ram #(.AW(ADDR_W), .DW(DATA_W)) u_ram (
    .clk(clk), .we(mem_wr), .addr(mar), .wdata(mbr), .rdata(ram_q));

  assign src[DRV_EXT] = sw_in[DATA_W-1:0];
  assign src[DRV_BUF] = mbr;
  assign src[DRV_RAM] = ram_q;

  bus_mux #(.N(NUM_DRV), .DW(DATA_W)) u_bus (
    .src(src), .en(drv_en), .bus(bus));

  always_ff @(posedge clk) begin
    if (rst) begin
      mar <= '0;
      mbr <= '0;
    end else begin
      if (addr_ld) mar <= sw_in;
      if (buf_ld)  mbr <= bus;
    end
  end

  assign disp_out = {bus, mbr};
endmodule

// File: rtl/memif_chk.sv
module memif_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 4
) (
  input logic                clk,
  input logic                rst,
  input logic [ADDR_W-1:0]   sw_in,
  input logic [2*DATA_W-1:0] disp_out,
  input logic                pulse_a,
  input logic                pulse_b,
  input logic                addr_ld,
  input logic                buf_ld,
  input logic                mem_wr,
  input logic [2:0]          drv_en,
  input logic [ADDR_W-1:0]   mar,
  input logic [DATA_W-1:0]   mbr
);
  // R10
  one_driver_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(drv_en) == 1);

  // R2
  mar_load_chk: assert property (@(posedge clk) disable iff (rst)
    addr_ld |=> mar == $past(sw_in));

  // R2
  mar_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !addr_ld |=> $stable(mar));

  // R3
  take_ext_chk: assert property (@(posedge clk) disable iff (rst)
    (pulse_b && sw_in[ADDR_W-1 -: 2] == 2'b00) |=> mbr == $past(sw_in[DATA_W-1:0]));

  // R6
  idle_chk: assert property (@(posedge clk) disable iff (rst)
    (pulse_b && sw_in[ADDR_W-1 -: 2] == 2'b01) |=> $stable(mbr) && $stable(mar));

  // R4
  store_only_chk: assert property (@(posedge clk) disable iff (rst)
    mem_wr |-> sw_in[ADDR_W-1 -: 2] == 2'b10);

  // R7
  one_shot_a_chk: assert property (@(posedge clk) disable iff (rst)
    pulse_a |=> !pulse_a);

  // R7
  one_shot_b_chk: assert property (@(posedge clk) disable iff (rst)
    pulse_b |=> !pulse_b);

  // R9
  buf_view_chk: assert property (@(posedge clk) disable iff (rst)
    !buf_ld |=> $stable(disp_out[DATA_W-1:0]));
endmodule

bind memif_top memif_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .sw_in(sw_in), .disp_out(disp_out),
  .pulse_a(pulse_a), .pulse_b(pulse_b), .addr_ld(addr_ld),
  .buf_ld(buf_ld), .mem_wr(mem_wr), .drv_en(drv_en),
  .mar(mar), .mbr(mbr));

// File: tb/sim_memif_top.sv
`timescale 1ns/1ps
module sim_memif_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] sw_in = 8'h00;
  logic       strobe_a = 1'b0;
  logic       strobe_b = 1'b0;
  logic [7:0] disp_out;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  memif_top u0 (.clk(clk), .rst(rst), .sw_in(sw_in),
    .strobe_a(strobe_a), .strobe_b(strobe_b), .disp_out(disp_out));

  // reference model
  int m_mar = 0, m_mbr = 0;
  int mem[int];
  bit ha0, ha1, ha2, hb0, hb1, hb2;

  always @(posedge clk) begin
    if (rst) begin
      m_mar = 0; m_mbr = 0;
      ha0 = 0; ha1 = 0; ha2 = 0; hb0 = 0; hb1 = 0; hb2 = 0;
    end else begin
      bit fa, fb;
      fa = ha1 && !ha2;
      fb = hb1 && !hb2;
      ha2 = ha1; ha1 = ha0; ha0 = strobe_a;
      hb2 = hb1; hb1 = hb0; hb0 = strobe_b;
      if (fb) begin
        case (sw_in[7:6])
          2'b00: m_mbr = int'(sw_in[3:0]);
          2'b10: mem[m_mar] = m_mbr;
          2'b11: if (mem.exists(m_mar)) m_mbr = mem[m_mar];
          default: ;
        endcase
      end
      if (fa) m_mar = int'(sw_in);
    end
  end

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s got=%0h exp=%0h at %0t", tag, got, exp, $time);
    end
  endtask

  // every-clock comparison against the model
  always @(negedge clk) begin
    #1;
    if (!rst && !done) begin
      int eb;
      bit known;
      known = 1;
      eb = 0;
      case (sw_in[7:6])
        2'b10: eb = m_mbr;
        2'b11: if (mem.exists(m_mar)) eb = mem[m_mar]; else known = 0;
        default: eb = int'(sw_in[3:0]);
      endcase
      chk("R9 buffer view", int'(disp_out[3:0]), m_mbr);
      if (known) chk("R8 bus view", int'(disp_out[7:4]), eb);
    end
  end

  task automatic press(input bit which_b, input logic [7:0] w, input int hold);
    @(negedge clk);
    sw_in = w;
    if (which_b) strobe_b = 1'b1; else strobe_a = 1'b1;
    repeat (hold) @(negedge clk);
    strobe_a = 1'b0; strobe_b = 1'b0;
    repeat (4) @(negedge clk);
    #1;
  endtask

  initial begin
    #(5.0 * 150000);
    failures++;
    $display("FAIL watchdog expired");
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    chk("R1 reset buffer", int'(disp_out[3:0]), 0);

    press(0, 8'h05, 1);                          // R2 address 5
    press(1, 8'h3A, 2);                          // R3 bits 5,4 set
    chk("R3 take ext ignores bits 5,4", int'(disp_out[3:0]), 'hA);
    press(1, 8'h80, 1);                          // R4 store A at 5
    chk("R4 buffer kept after store", int'(disp_out[3:0]), 'hA);
    chk("R8 buffer drives bus", int'(disp_out[7:4]), 'hA);
    press(1, 8'h03, 1);
    chk("R3 take ext", int'(disp_out[3:0]), 3);
    @(negedge clk); sw_in = 8'hC0; #1;
    chk("R8 ram drives bus", int'(disp_out[7:4]), 'hA);
    chk("R9 buffer shown while ram drives", int'(disp_out[3:0]), 3);
    press(1, 8'hC0, 1);
    chk("R5 fetch", int'(disp_out[3:0]), 'hA);

    press(1, 8'h03, 1);
    press(1, 8'h4F, 3);                          // R6 idle
    chk("R6 idle buffer", int'(disp_out[3:0]), 3);
    @(negedge clk); sw_in = 8'hC0; #1;
    chk("R6 idle ram word", int'(disp_out[7:4]), 'hA);

    // R7 latency: acts on third sampling edge
    @(negedge clk); sw_in = 8'h0C; strobe_b = 1'b1;
    @(posedge clk); @(posedge clk); #1;
    chk("R7 not yet", int'(disp_out[3:0]), 3);
    @(posedge clk); #1;
    chk("R7 acted", int'(disp_out[3:0]), 'hC);
    @(negedge clk); strobe_b = 1'b0; repeat (4) @(negedge clk);

    // R7 long hold with word changed mid-press
    @(negedge clk); sw_in = 8'h07; strobe_a = 1'b1;
    repeat (6) @(negedge clk);
    sw_in = 8'h09;
    repeat (15) @(negedge clk);
    strobe_a = 1'b0; repeat (4) @(negedge clk);
    press(1, 8'h06, 1);
    press(1, 8'h80, 1);                          // store 6 at address 7
    press(1, 8'h01, 1);
    press(0, 8'h07, 1);
    press(1, 8'hC0, 1);
    chk("R7 single load during hold", int'(disp_out[3:0]), 6);

    // R4 R5 several addresses
    for (int i = 0; i < 8; i++) begin
      press(0, 8'(i * 17 + 1), 1);
      press(1, 8'(i ^ 5), 1);
      press(1, 8'h80, 1);
    end
    for (int i = 0; i < 8; i++) begin
      press(0, 8'(i * 17 + 1), 1);
      press(1, 8'h00, 1);
      press(1, 8'hC0, 1);
      chk("R5 readback", int'(disp_out[3:0]), i ^ 5);
    end

    rst = 1'b1; @(negedge clk); rst = 1'b0; #1;
    chk("R1 reset again", int'(disp_out[3:0]), 0);
    repeat (2) @(negedge clk);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule